// File: doc/BRIEF.md
# Call Graph History Prefetcher

This block learns, for each function it has seen called, the order in which that function last called other functions. It then uses that order to guess which function will run next. A small fully associative table is keyed by function id. Each entry holds a short list of callee ids, a valid bit per list slot, and a cursor into the list.

The pipeline gives the block one event per cycle. A call event names the caller and the callee. A return event names the function that is returning and the function control returns to. A call looks up the callee, creating an entry if the callee is unknown, and hints at the callee's first recorded callee. The call also writes the callee into the caller's list at the caller's cursor. A return rewinds the returning function's cursor. It then moves the cursor of the function being returned to and hints at the callee stored there.

Hints leave through a one-deep register with a valid/ready handshake. A hint that arrives while that register is stalled is lost. Translating ids to addresses is done elsewhere.

Top module: `cg_hist_prefetch`

## Requirements
- R1: After reset, no entry is present and `pf_valid` is 0.
- R2: A call (`ev_is_ret`=0) whose callee (`ev_to`) is absent allocates the entry at the round-robin pointer. The new entry has all slots invalid and cursor 0, and the pointer then advances by one, wrapping after the last entry. No prefetch comes from this event.
- R3: A call whose callee is present loads that callee's slot 0 into the output register. `pf_valid`=1 and `pf_id`=slot value in the cycle after the event edge.
- R4: A call whose caller (`ev_from`) is present writes the callee id into the caller's slot at the caller's cursor and marks that slot valid. The cursor is unchanged. The write is skipped when the caller's entry is the one being replaced by the same event.
- R5: A return (`ev_is_ret`=1) whose returning function (`ev_from`) is present sets that function's cursor to 0.
- R6: A return whose target (`ev_to`) is present advances the target's cursor by one, saturating at slot 3, and loads the slot at the new cursor as a prefetch. When the returning function and the target are the same entry, the advance wins over the rewind.
- R7: No prefetch is produced when the slot selected by R3 or R6 is invalid.
- R8: While `pf_valid`=1 and `pf_ready`=0, `pf_id` holds and any new prefetch is dropped. With `pf_ready`=1 the register empties, or takes a new prefetch in the same cycle.
- R9: The table has 8 entries, each tag is present at most once, and a replaced entry keeps none of its history.
- R10: Inputs are ignored while `ev_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_is_ret | input | 1 | 0 = call, 1 = return |
| ev_from | input | 8 | Caller (call) or returning function (return) |
| ev_to | input | 8 | Callee (call) or function returned to (return) |
| pf_valid | output | 1 | Prefetch hint pending |
| pf_id | output | 8 | Function id to prefetch |
| pf_ready | input | 1 | Consumer accepts the hint |

## Verification
A directed call and return script builds one caller's list and then replays it. This separates the slot-0 hint on call, the advancing hint on return, and the suppression for empty slots. Overwriting slot 0 after a rewind shows that the cursor really returned to 0. A burst of calls to eight fresh ids then evicts a known entry, which shows that its history is gone. A constrained random stream follows, drawn from twelve ids with random idle cycles and random back-pressure. It mixes hits, evictions, recursion and stalled hints, and a bench reference model checks every cycle.

// File: rtl/cg_hist_prefetch.sv
module cg_hist_prefetch #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 4,
  parameter int ID_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic            ev_is_ret,
  input  logic [ID_W-1:0] ev_from,
  input  logic [ID_W-1:0] ev_to,
  output logic            pf_valid,
  output logic [ID_W-1:0] pf_id,
  input  logic            pf_ready
);
  localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);
  localparam logic [EW-1:0] ELAST = EW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [ID_W-1:0]    tag_q  [ENTRIES];
  logic [ID_W-1:0]    slot_q [ENTRIES][SLOTS];
  logic [SLOTS-1:0]   sv_q   [ENTRIES];
  logic [IW-1:0]      cur_q  [ENTRIES];
  logic [EW-1:0]      rr_q;

  logic [ENTRIES-1:0] m_a, m_b;
  logic [EW-1:0]      ia, ib;
  logic               hit_a, hit_b;

  always_comb begin
    ia = '0;
    ib = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      m_a[e] = vld_q[e] && (tag_q[e] == ev_from);
      m_b[e] = vld_q[e] && (tag_q[e] == ev_to);
      if (m_a[e]) ia = EW'(e);
      if (m_b[e]) ib = EW'(e);
    end
  end
  assign hit_a = |m_a;
  assign hit_b = |m_b;

  logic [IW-1:0]   nxt;
  logic [IW-1:0]   sel;
  logic            cand_v;
  logic            load;
  logic            rec;

  assign nxt    = (cur_q[ib] == LAST) ? cur_q[ib] : cur_q[ib] + 1'b1;
  assign sel    = ev_is_ret ? nxt : '0;
  assign cand_v = ev_valid && hit_b && sv_q[ib][sel];
  assign load   = cand_v && (!pf_valid || pf_ready);
  assign rec    = ev_valid && !ev_is_ret && hit_a && (hit_b || ia != rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      rr_q     <= '0;
      pf_valid <= 1'b0;
      pf_id    <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e] <= '0;
        sv_q[e]  <= '0;
        cur_q[e] <= '0;
        for (int s = 0; s < SLOTS; s++) slot_q[e][s] <= '0;
      end
    end else begin
      if (pf_valid && pf_ready) pf_valid <= 1'b0;
      if (load) begin
        pf_valid <= 1'b1;
        pf_id    <= slot_q[ib][sel];
      end
      if (rec) begin
        slot_q[ia][cur_q[ia]] <= ev_to;
        sv_q[ia][cur_q[ia]]   <= 1'b1;
      end
      if (ev_valid && !ev_is_ret && !hit_b) begin
        vld_q[rr_q] <= 1'b1;
        tag_q[rr_q] <= ev_to;
        sv_q[rr_q]  <= '0;
        cur_q[rr_q] <= '0;
        rr_q        <= (rr_q == ELAST) ? '0 : rr_q + 1'b1;
      end
      if (ev_valid && ev_is_ret) begin
        if (hit_a) cur_q[ia] <= '0;
        if (hit_b) cur_q[ib] <= nxt;
      end
    end
  end

  p_pf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_id));

  p_tag_unique_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_a) && $onehot0(m_b));

  p_alloc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_is_ret && !hit_b && !(pf_valid && !pf_ready) |=> !pf_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid && !(pf_valid && !pf_ready) |=> !pf_valid);
endmodule

// File: tb/cg_hist_prefetch_tb.sv
`timescale 1ns/1ps
module cg_hist_prefetch_tb_top;
  localparam int E = 8, S = 4;
  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_is_ret = 0, pf_ready = 1;
  logic [7:0] ev_from = 0, ev_to = 0;
  logic pf_valid;
  logic [7:0] pf_id;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cg_hist_prefetch dut_i (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_ret(ev_is_ret),
    .ev_from(ev_from), .ev_to(ev_to), .pf_valid(pf_valid), .pf_id(pf_id), .pf_ready(pf_ready));

  bit m_v [E]; logic [7:0] m_tag [E]; logic [7:0] m_sl [E][S]; bit m_sv [E][S];
  int m_cur [E]; int m_rr; bit m_pv; logic [7:0] m_pid; string m_req;

  function automatic int find(logic [7:0] id);
    for (int e = 0; e < E; e++) if (m_v[e] && m_tag[e] == id) return e;
    return -1;
  endfunction

  task automatic model_step();
    bit full = m_pv && !pf_ready;
    bit cv = 0; logic [7:0] cid = 0;
    int a, b, n;
    if (m_pv && pf_ready) m_pv = 0;
    m_req = full ? "R8" : "R10";
    if (!ev_valid) return;
    a = find(ev_from); b = find(ev_to);
    if (!ev_is_ret) begin
      if (b >= 0) begin cv = m_sv[b][0]; cid = m_sl[b][0]; m_req = cv ? "R3" : "R7"; end
      else m_req = "R2";
      if (a >= 0 && (b >= 0 || a != m_rr)) begin m_sl[a][m_cur[a]] = ev_to; m_sv[a][m_cur[a]] = 1; end
      if (b < 0) begin
        m_v[m_rr] = 1; m_tag[m_rr] = ev_to; m_cur[m_rr] = 0;
        for (int s = 0; s < S; s++) m_sv[m_rr][s] = 0;
        m_rr = (m_rr + 1) % E;
      end
    end else begin
      if (b >= 0) begin
        n = (m_cur[b] == S-1) ? m_cur[b] : m_cur[b] + 1;
        cv = m_sv[b][n]; cid = m_sl[b][n]; m_req = cv ? "R6" : "R7";
      end else m_req = "R5";
      if (a >= 0) m_cur[a] = 0;
      if (b >= 0) m_cur[b] = n;
    end
    if (full) m_req = "R8";
    if (cv && !full) begin m_pv = 1; m_pid = cid; end
  endtask

  task automatic chk(bit ev, logic [7:0] ei, bit av, logic [7:0] ai, string req);
    checks++;
    if (av !== ev || (ev && ai !== ei)) begin
      fails++;
      $display("FAIL %s: pf_valid=%0b pf_id=%0d expected pf_valid=%0b pf_id=%0d", req, av, ai, ev, ei);
    end
  endtask

  task automatic cyc(bit v, bit r, logic [7:0] f, logic [7:0] t, bit rdy);
    ev_valid = v; ev_is_ret = r; ev_from = f; ev_to = t; pf_ready = rdy;
    @(posedge clk); model_step(); @(negedge clk);
  endtask

  task automatic dir(bit r, logic [7:0] f, logic [7:0] t, bit xv, logic [7:0] xi, string req);
    cyc(1, r, f, t, 1);
    chk(xv, xi, pf_valid, pf_id, req);
    chk(m_pv, m_pid, pf_valid, pf_id, req);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < E; e++) begin m_v[e] = 0; m_cur[e] = 0; end
    m_rr = 0; m_pv = 0; m_pid = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(0, 0, pf_valid, pf_id, "R1");
    dir(0, 1, 2, 0, 0, "R2");   // 2 allocated in entry 0
    dir(0, 2, 3, 0, 0, "R4");   // slot0 of 2 = 3
    dir(1, 3, 2, 0, 0, "R7");   // cursor of 2 -> 1, slot1 empty
    dir(0, 2, 4, 0, 0, "R4");   // slot1 of 2 = 4
    dir(1, 4, 2, 0, 0, "R7");   // cursor of 2 -> 2, empty
    dir(1, 2, 1, 0, 0, "R5");   // cursor of 2 -> 0
    dir(0, 1, 2, 1, 3, "R3");   // hint slot0 = 3
    dir(0, 2, 5, 0, 0, "R5");   // records at cursor 0: slot0 = 5
    dir(1, 5, 2, 1, 4, "R6");   // cursor 1, hint 4
    dir(0, 1, 2, 1, 5, "R5");   // slot0 overwritten proves rewind
    cyc(0, 0, 9, 2, 1);
    chk(0, 0, pf_valid, pf_id, "R10");
    cyc(1, 0, 1, 2, 0);         // hint 5 loaded, stalled
    cyc(1, 1, 5, 2, 0);         // would hint slot2 (empty) anyway
    cyc(1, 1, 3, 2, 0);
    chk(1, 5, pf_valid, pf_id, "R8");
    cyc(0, 0, 0, 0, 1);
    chk(0, 0, pf_valid, pf_id, "R8");
    for (int k = 0; k < 8; k++) begin
      cyc(1, 0, 0, 8'(10 + k), 1);
      chk(0, 0, pf_valid, pf_id, "R9");
    end
    dir(0, 1, 2, 0, 0, "R9");   // 2 was evicted, history gone
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(0, 4) != 0, $urandom_range(0, 1), 8'($urandom_range(0, 11)),
          8'($urandom_range(0, 11)), $urandom_range(0, 1));
      chk(m_pv, m_pid, pf_valid, pf_id, m_req);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule